// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from 32 sources and tells the processor the most urgent pending level. Six sources are external pins. The other 26 come from on-chip peripherals such as timers, USB endpoints, serial ports, a line-interface unit, DMA and a software watchdog. Each source has a 3-bit priority level. Level 0 switches the source off, and levels 1 to 7 are active. The output level is the largest level among the pending, enabled sources. When the processor acknowledges, the block returns an 8-bit vector. The vector is a 3-bit base followed by the 5-bit index of the winning source.

Each external pin passes through a two-flop synchroniser and a per-pin polarity select. A pin must then hold its active level for three consecutive sampled clocks before the block latches a request. The latched request stays set until software clears it through the level registers. Internal sources are level requests and are not latched. No level is presented until software has written the vector base register at least once after reset.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset, `irq_lvl_o` is 0 and `vec_vld_o` is 0. The pending register (0x10) reads 0, the base register (0x18) reads 0x40, and the polarity register (0x14) reads 0x3F.
- R2: Until the base register has been written once after reset, `irq_lvl_o` stays 0 and an acknowledge returns no vector.
- R3: A write to 0x18 keeps data bits [7:5] as the base. A value below 64 is stored as base 3'b010. Reading 0x18 returns the base in bits [7:5] and zeros elsewhere.
- R4: The level of source i is held in register 0x00 + 4*(i/8), in bits [4*(i%8)+2 : 4*(i%8)]. A level of 0 disables the source. One clock after a change in pending requests, `irq_lvl_o` shows the highest level among pending enabled sources.
- R5: Among pending sources that share the highest level, the lowest index wins. Indices 0 to 5 are external pins 1 to 6, and indices 6 to 31 are `int_irq_i[0..25]`. The vector is {base, index}.
- R6: Bit k of 0x14 selects the active level of external pin k: 1 means high (rising edge), 0 means low (falling edge). After reset all pins use the rising edge.
- R7: An external pin that holds its active level for fewer than 3 consecutive clocks sets no request. A pin that holds it for 3 clocks sets the request.
- R8: A latched external request stays set after the pin returns to inactive. A pin held active for a long time latches only one request.
- R9: Writing bit 4k+3 of 0x00 to 1 clears the pending request of external pin k. If a filtered edge arrives in the same clock as the clear, the request stays set.
- R10: Internal sources are level requests. The pending register (0x10) shows them in bits [31:6] and the external latches in bits [5:0], and an internal request drops as soon as its input drops.
- R11: If `iack_i` is high while `irq_lvl_o` is nonzero, then on the next clock `vec_vld_o` goes high and `vec_o` holds the vector. If `irq_lvl_o` is 0, `vec_vld_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Register write enable |
| bus_rdata | output | 32 | Register read data (combinational) |
| ext_irq_i | input | 6 | External interrupt pins (asynchronous) |
| int_irq_i | input | 26 | Internal level requests |
| irq_lvl_o | output | 3 | Highest pending priority level |
| iack_i | input | 1 | Processor acknowledge |
| vec_o | output | 8 | Returned vector |
| vec_vld_o | output | 1 | Vector valid strobe |

## Verification
Two events can land on an external pin's pending latch in the same clock: a software clear and a new filtered edge. The bench raises the pin and counts the clock edges. The edge that would latch the request is the fifth one: two synchroniser stages followed by three filter samples. The bench times a clear write so that it commits on exactly that edge. The pending register must then read 1, because a new event must never be lost. The bench also confirms, in separate steps, that a clear on its own empties the latch and that a three-clock pulse on its own sets it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int NUM_SRC      = 32;
    localparam int NUM_EXT      = 6;
    localparam int LVL_W        = 3;
    localparam int IDX_W        = $clog2(NUM_SRC);
    localparam int VEC_W        = 8;
    localparam int BASE_W       = VEC_W - IDX_W;
    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 32;
    localparam int NIB          = 4;
    localparam int SRC_PER_WORD = DATA_W / NIB;
    localparam int FILT_LEN     = 3;
    localparam int MIN_VEC      = 64;

    localparam logic [ADDR_W-1:0] A_LVL0 = 8'h00;
    localparam logic [ADDR_W-1:0] A_PEND = 8'h10;
    localparam logic [ADDR_W-1:0] A_EDGE = 8'h14;
    localparam logic [ADDR_W-1:0] A_BASE = 8'h18;
    localparam logic [BASE_W-1:0] BASE_MIN = BASE_W'(MIN_VEC >> IDX_W);

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic any;
        lvl_t lvl;
        idx_t idx;
    } win_t;

    function automatic logic [ADDR_W-1:0] lvl_addr(input int src);
        return A_LVL0 + ADDR_W'((src / SRC_PER_WORD) * 4);
    endfunction

    function automatic logic [BASE_W-1:0] legal_base(input logic [VEC_W-1:0] w);
        return (w < VEC_W'(MIN_VEC)) ? BASE_MIN : w[VEC_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/irq_ext_filter.sv
module irq_ext_filter #(
    parameter int FILT = irq_prio_pkg::FILT_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);
    localparam int CW = $clog2(FILT + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          act;

    assign act = rise_sel ? sync_q[1] : ~sync_q[1];
    assign hit = act && (run_q == CW'(FILT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            run_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], pin};
            if (!act)
                run_q <= '0;
            else if (run_q != CW'(FILT))
                run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_prio_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] req,
    input  lvl_t         lvl [N],
    output win_t         win
);
    always_comb begin
        win = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i] && lvl[i] != '0 && lvl[i] >= win.lvl) begin
                win.any = 1'b1;
                win.lvl = lvl[i];
                win.idx = idx_t'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
    import irq_prio_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int N_EXT = NUM_EXT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic                   bus_we,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [N_EXT-1:0]       ext_irq_i,
    input  logic [N_SRC-N_EXT-1:0] int_irq_i,
    output logic [LVL_W-1:0]       irq_lvl_o,
    input  logic                   iack_i,
    output logic [VEC_W-1:0]       vec_o,
    output logic                   vec_vld_o
);
    lvl_t              lvl_q [N_SRC];
    logic [N_EXT-1:0]  rise_q;
    logic [N_EXT-1:0]  ext_pend;
    logic [N_EXT-1:0]  hit;
    logic [N_EXT-1:0]  clr;
    logic [BASE_W-1:0] base_q;
    logic              base_wr_q;
    idx_t              win_idx_q;
    logic [N_SRC-1:0]  req;
    win_t              win;
    logic              unused_bits;

    assign unused_bits = ^bus_wdata;
    assign req = {int_irq_i, ext_pend};

    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
        irq_ext_filter #(.FILT(FILT_LEN)) u_filt (
            .clk      (clk),
            .rst      (rst),
            .pin      (ext_irq_i[k]),
            .rise_sel (rise_q[k]),
            .hit      (hit[k])
        );
        assign clr[k] = bus_we && (bus_addr == lvl_addr(k))
                        && bus_wdata[(k % SRC_PER_WORD) * NIB + LVL_W];
    end

    irq_prio_arb #(.N(N_SRC)) u_arb (
        .req (req),
        .lvl (lvl_q),
        .win (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SRC; i++) lvl_q[i] <= '0;
            rise_q    <= '1;
            ext_pend  <= '0;
            base_q    <= BASE_MIN;
            base_wr_q <= 1'b0;
            irq_lvl_o <= '0;
            win_idx_q <= '0;
            vec_o     <= '0;
            vec_vld_o <= 1'b0;
        end else begin
            if (bus_we) begin
                for (int i = 0; i < N_SRC; i++)
                    if (bus_addr == lvl_addr(i))
                        lvl_q[i] <= bus_wdata[(i % SRC_PER_WORD) * NIB +: LVL_W];
                if (bus_addr == A_EDGE)
                    rise_q <= bus_wdata[N_EXT-1:0];
                if (bus_addr == A_BASE) begin
                    base_q    <= legal_base(bus_wdata[VEC_W-1:0]);
                    base_wr_q <= 1'b1;
                end
            end
            ext_pend  <= hit | (ext_pend & ~clr);
            irq_lvl_o <= (base_wr_q && win.any) ? win.lvl : '0;
            win_idx_q <= win.idx;
            vec_vld_o <= iack_i && (irq_lvl_o != '0);
            if (iack_i)
                vec_o <= {base_q, win_idx_q};
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_SRC; i++)
            if (bus_addr == lvl_addr(i))
                bus_rdata[(i % SRC_PER_WORD) * NIB +: LVL_W] = lvl_q[i];
        if (bus_addr == A_PEND) bus_rdata = DATA_W'(req);
        if (bus_addr == A_EDGE) bus_rdata = DATA_W'(rise_q);
        if (bus_addr == A_BASE) bus_rdata = DATA_W'({base_q, IDX_W'(0)});
    end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             base_wr,
    input logic [LVL_W-1:0] irq_lvl,
    input logic             iack,
    input logic [VEC_W-1:0] vec,
    input logic             vec_vld
);
    // R2: no level is shown before the base register has been written
    p_gate_until_base_r2: assert property (@(posedge clk) disable iff (rst)
        !base_wr |-> irq_lvl == '0);

    // R3: a returned vector never falls below 64
    p_vec_floor_r3: assert property (@(posedge clk) disable iff (rst)
        vec_vld |-> vec >= VEC_W'(MIN_VEC));

    // R11: the valid strobe follows an acknowledge taken while a level was shown
    p_vld_after_ack_r11: assert property (@(posedge clk) disable iff (rst)
        vec_vld |-> ($past(iack) && $past(irq_lvl) != '0));

    // R11: the vector only moves when an acknowledge is taken
    p_vec_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !iack |=> $stable(vec));
endmodule

bind irq_prio_ctl irq_prio_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .base_wr (base_wr_q),
    .irq_lvl (irq_lvl_o),
    .iack    (iack_i),
    .vec     (vec_o),
    .vec_vld (vec_vld_o)
);

// File: tb/tb_irq_prio_ctl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [5:0]  ext_irq_i = '0;
    logic [25:0] int_irq_i = '0;
    logic [2:0]  irq_lvl_o;
    logic        iack_i = 1'b0;
    logic [7:0]  vec_o;
    logic        vec_vld_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .ext_irq_i(ext_irq_i),
        .int_irq_i(int_irq_i), .irq_lvl_o(irq_lvl_o), .iack_i(iack_i),
        .vec_o(vec_o), .vec_vld_o(vec_vld_o)
    );

    // {internal request pattern, expected level, expected winner index}
    localparam logic [33:0] TBL [12] = '{
        {26'h0000001, 3'd3, 5'd6},  {26'h0000003, 3'd3, 5'd6},
        {26'h0000002, 3'd3, 5'd7},  {26'h0000006, 3'd5, 5'd8},
        {26'h0000008, 3'd0, 5'd0},  {26'h0000030, 3'd7, 5'd10},
        {26'h0000020, 3'd7, 5'd11}, {26'h2000000, 3'd1, 5'd31},
        {26'h2000008, 3'd1, 5'd31}, {26'h2100000, 3'd1, 5'd26},
        {26'h000003F, 3'd7, 5'd10}, {26'h0000041, 3'd3, 5'd6}
    };

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack(input string tag, input logic exp_vld, input logic [7:0] exp_vec);
        iack_i = 1'b1;
        tick();
        iack_i = 1'b0;
        check(tag, {31'd0, vec_vld_o}, {31'd0, exp_vld});
        if (exp_vld) check(tag, {24'd0, vec_o}, {24'd0, exp_vec});
    endtask

    task automatic pulse(input int k, input int len);
        ext_irq_i[k] = ~ext_irq_i[k];
        tick(len);
        ext_irq_i[k] = ~ext_irq_i[k];
    endtask

    initial begin
        logic [31:0] r;
        tick(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 lvl", {29'd0, irq_lvl_o}, 32'd0);
        check("R1 vld", {31'd0, vec_vld_o}, 32'd0);
        rd(8'h10, r); check("R1 pend", r, 32'd0);
        rd(8'h18, r); check("R1 base", r, 32'h40);
        rd(8'h14, r); check("R1/R6 edge reset", r, 32'h3F);

        // level setup
        wr(8'h00, 32'h3300_0000);
        wr(8'h04, 32'h1111_7705);
        wr(8'h08, 32'h1111_1111);
        wr(8'h0C, 32'h1111_1111);
        rd(8'h04, r); check("R4 level readback", r, 32'h1111_7705);

        // R2 gating before base write
        int_irq_i = 26'h1;
        tick(3);
        check("R2 gated lvl", {29'd0, irq_lvl_o}, 32'd0);
        ack("R2 gated ack", 1'b0, 8'h00);

        // R3 base clamp and readback
        wr(8'h18, 32'h10);
        rd(8'h18, r); check("R3 clamp", r, 32'h40);
        wr(8'h18, 32'hA7);
        rd(8'h18, r); check("R3 base", r, 32'hA0);
        tick(2);
        check("R2 ungated lvl", {29'd0, irq_lvl_o}, 32'd3);

        // R4 / R5 / R10 / R11 table
        for (int e = 0; e < 12; e++) begin
            int_irq_i = TBL[e][33:8];
            tick(2);
            check("R4 table lvl", {29'd0, irq_lvl_o}, {29'd0, TBL[e][7:5]});
            ack("R5/R11 table vec", TBL[e][7:5] != 3'd0, {3'b101, TBL[e][4:0]});
        end
        int_irq_i = '0;
        tick(2);
        check("R10 drop", {29'd0, irq_lvl_o}, 32'd0);
        rd(8'h10, r); check("R10 pend empty", r, 32'd0);

        // R7 filter
        wr(8'h00, 32'h3300_0006);
        pulse(0, 2);
        tick(6);
        rd(8'h10, r); check("R7 short pulse", r, 32'd0);
        check("R7 short lvl", {29'd0, irq_lvl_o}, 32'd0);
        pulse(0, 3);
        tick(6);
        rd(8'h10, r); check("R7/R8 latched", r, 32'd1);
        check("R8 lvl", {29'd0, irq_lvl_o}, 32'd6);
        ack("R5 ext vec", 1'b1, 8'hA0);

        // R9 clear
        wr(8'h00, 32'h3300_000E);
        rd(8'h10, r); check("R9 cleared", r, 32'd0);
        rd(8'h00, r); check("R9 level kept", r, 32'h3300_0006);
        tick();
        check("R9 lvl gone", {29'd0, irq_lvl_o}, 32'd0);

        // R8 one event per long assertion
        ext_irq_i[0] = 1'b1;
        tick(8);
        rd(8'h10, r); check("R8 held", r, 32'd1);
        wr(8'h00, 32'h3300_000E);
        tick(8);
        rd(8'h10, r); check("R8 single event", r, 32'd0);
        ext_irq_i[0] = 1'b0;
        tick(8);

        // R9 set and clear in the same clock
        ext_irq_i[0] = 1'b1;
        tick(4);
        bus_addr = 8'h00; bus_wdata = 32'h3300_000E; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
        rd(8'h10, r); check("R9 set wins", r, 32'd1);
        ext_irq_i[0] = 1'b0;
        tick(6);
        wr(8'h00, 32'h3300_000E);

        // R6 falling edge on pin 1
        wr(8'h00, 32'h3300_0046);
        ext_irq_i[1] = 1'b1;
        tick(8);
        rd(8'h10, r); check("R6 rising", r, 32'd2);
        wr(8'h14, 32'h3D);
        wr(8'h00, 32'h3300_00C6);
        tick(6);
        rd(8'h10, r); check("R6 high inactive", r, 32'd0);
        pulse(1, 2);
        tick(6);
        rd(8'h10, r); check("R6/R7 short low", r, 32'd0);
        pulse(1, 3);
        tick(6);
        rd(8'h10, r); check("R6 falling", r, 32'd2);
        check("R6 lvl", {29'd0, irq_lvl_o}, 32'd4);
        wr(8'h00, 32'h3300_00C6);

        // R5 tie between external pin 1 (index 0) and internal index 10
        wr(8'h00, 32'h3300_0007);
        pulse(0, 3);
        int_irq_i = 26'h10;
        tick(6);
        check("R5 tie lvl", {29'd0, irq_lvl_o}, 32'd7);
        ack("R5 tie vec", 1'b1, 8'hA0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule